// File: doc/BRIEF.md
# Hot-Swap Channel Fault Timer with Restart Control

This block guards one switched power channel. While the channel is on and the analog side reports that it is holding the load in current limit, the block measures how long that condition lasts. The measurement runs against a programmable budget. If the budget runs out, or if a fast-trip comparator fires, the block drops the channel's gate enable. It then does one of two things. In latch-off mode it keeps the channel off until software removes the enable and applies it again. In auto-retry mode it waits through a cooldown and then turns the channel back on by itself.

Time is taken from a free-running 1 µs tick. A prescaler turns that tick into a coarse unit of PRESCALE ticks, which is 0.45 ms by default. The fault budget is the 5-bit code times one unit, so each code bit carries a binary weight. A code of zero runs as a code of one, which matches the register's reset value. The cooldown lasts 2^COOL_SHIFT times the fault budget. Three single-cycle event pulses feed a status register: budget expired, entry into current limit, and fast trip.

Top module: `fault_timer_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, gate_en_o, fault_evt_o, oc_evt_o and ft_evt_o are all 0.
- R2: With en_i low the channel goes off on the next clock edge from any state. Over-current and fast-trip inputs then raise no events. Raising en_i turns gate_en_o on at the next edge.
- R3: The channel turns off at the edge where over-current has been sampled high with tick_i high for PRESCALE × max(ft_code_i, 1) edges in a row. A code of 0 gives the same time as a code of 1.
- R4: If over-current drops before the budget is used up, the accumulated time is discarded. The next over-current episode then needs the full budget again.
- R5: With retry_mode_i = 0, a channel turned off by a fault stays off while en_i stays high. Only a low-then-high sequence on en_i turns it back on.
- R6: With retry_mode_i = 1, a faulted channel turns back on after 16 × PRESCALE × max(ft_code_i, 1) further ticks.
- R7: When fast_trip_i is sampled high while the channel is on, the gate goes off at that edge without waiting for the timer. ft_evt_o pulses for one cycle. The channel then latches or retries according to retry_mode_i, exactly as after a timer fault.
- R8: fault_evt_o is a one-cycle pulse in the cycle where gate_en_o first reads 0 after a timer expiry. It never coincides with ft_evt_o.
- R9: oc_evt_o pulses for one cycle after an edge where over-current rises from 0 to 1 while the channel is on.
- R10: The timers advance only on edges where tick_i is high. Clock edges without a tick add no time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 µs time-base strobe |
| en_i | input | 1 | Channel enable |
| oc_i | input | 1 | Channel is in current limit (synchronous) |
| fast_trip_i | input | 1 | Fast-trip comparator output (synchronous) |
| ft_code_i | input | CODE_W | Fault budget in prescaled units |
| retry_mode_i | input | 1 | 0 = latch off after fault, 1 = auto-retry |
| gate_en_o | output | 1 | Gate enable for the channel's pass device |
| fault_evt_o | output | 1 | Pulse: fault budget expired |
| oc_evt_o | output | 1 | Pulse: channel entered current limit |
| ft_evt_o | output | 1 | Pulse: fast trip tripped the channel |

## Verification
The stimulus applies over-current in bursts. One burst is shorter than the budget, followed by a gap and a second, full-length burst. This separates a timer that restarts from zero (R4) from one that keeps accumulating. Zero and non-zero codes are run under both mode settings, so latch-off and retry are seen after timer faults as well as after fast trips. The cooldown length is compared against the budget it scales from. A run with the tick present on only every other edge shows whether the count follows ticks or raw clocks. A disabled channel is fed over-current and fast trip to confirm that they produce no event.

// File: rtl/ft_pkg.sv
package ft_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ON    = 2'd1,
    ST_LATCH = 2'd2,
    ST_COOL  = 2'd3
  } ft_state_e;
endpackage

// File: rtl/ft_prescaler.sv
module ft_prescaler #(
  parameter int PRESCALE = 450
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic stb_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0] cnt_q;
  logic          last;

  assign last  = (cnt_q == PW'(PRESCALE - 1));
  assign stb_o = en_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= last ? '0 : cnt_q + PW'(1);
  end
endmodule

// File: rtl/ft_unit_counter.sv
module ft_unit_counter #(
  parameter int UW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          stb_i,
  input  logic [UW-1:0] limit_i,
  output logic          done_o
);
  logic [UW-1:0] cnt_q;

  // limit_i is never zero
  assign done_o = stb_i & (cnt_q == limit_i - UW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || done_o) cnt_q <= '0;
    else if (stb_i)           cnt_q <= cnt_q + UW'(1);
  end
endmodule

// File: rtl/fault_timer_ctrl.sv
module fault_timer_ctrl
  import ft_pkg::*;
#(
  parameter int PRESCALE   = 450,
  parameter int CODE_W     = 5,
  parameter int COOL_SHIFT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              oc_i,
  input  logic              fast_trip_i,
  input  logic [CODE_W-1:0] ft_code_i,
  input  logic              retry_mode_i,
  output logic              gate_en_o,
  output logic              fault_evt_o,
  output logic              oc_evt_o,
  output logic              ft_evt_o
);
  localparam int UW = CODE_W + COOL_SHIFT;

  ft_state_e         state_q, state_d;
  logic [CODE_W-1:0] eff_code;
  logic [UW-1:0]     fault_lim, cool_lim, limit;
  logic              run, clr, unit_stb, done;
  logic              is_on;
  logic              oc_prev_q, fault_evt_q, oc_evt_q, ft_evt_q;

  assign eff_code  = (ft_code_i == '0) ? CODE_W'(1) : ft_code_i;
  assign fault_lim = UW'(eff_code);
  assign cool_lim  = fault_lim << COOL_SHIFT;

  assign is_on = (state_q == ST_ON);
  assign run   = (is_on & oc_i) | (state_q == ST_COOL);
  assign limit = (state_q == ST_COOL) ? cool_lim : fault_lim;
  // any state change restarts the shared time base
  assign clr   = ~run | (state_d != state_q);

  ft_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .en_i   (run & tick_i),
    .stb_o  (unit_stb)
  );

  ft_unit_counter #(.UW(UW)) u_units (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .stb_i   (unit_stb),
    .limit_i (limit),
    .done_o  (done)
  );

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:   state_d = ST_ON;
        ST_ON:    if (fast_trip_i || done) state_d = retry_mode_i ? ST_COOL : ST_LATCH;
        ST_LATCH: state_d = ST_LATCH;
        ST_COOL:  if (done) state_d = ST_ON;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_OFF;
      oc_prev_q   <= 1'b0;
      fault_evt_q <= 1'b0;
      oc_evt_q    <= 1'b0;
      ft_evt_q    <= 1'b0;
    end else begin
      state_q     <= state_d;
      oc_prev_q   <= oc_i;
      fault_evt_q <= en_i & is_on & ~fast_trip_i & done;
      ft_evt_q    <= en_i & is_on & fast_trip_i;
      oc_evt_q    <= en_i & is_on & oc_i & ~oc_prev_q;
    end
  end

  assign gate_en_o   = is_on;
  assign fault_evt_o = fault_evt_q;
  assign oc_evt_o    = oc_evt_q;
  assign ft_evt_o    = ft_evt_q;
endmodule

// File: rtl/fault_timer_ctrl_chk.sv
module fault_timer_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic oc_i,
  input logic fast_trip_i,
  input logic gate_en_o,
  input logic fault_evt_o,
  input logic oc_evt_o,
  input logic ft_evt_o
);
  p_disable_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !gate_en_o);

  p_on_needs_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_en_o) |-> $past(en_i));

  p_fast_trip_cut_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_en_o && en_i && fast_trip_i) |=> (!gate_en_o && ft_evt_o));

  p_fault_with_gate_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_evt_o |-> (!gate_en_o && $past(gate_en_o)));

  p_fault_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_evt_o |=> !fault_evt_o);

  p_evt_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fault_evt_o, ft_evt_o}));

  p_oc_evt_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_evt_o |-> ($past(oc_i) && $past(gate_en_o)));
endmodule

bind fault_timer_ctrl fault_timer_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .oc_i        (oc_i),
  .fast_trip_i (fast_trip_i),
  .gate_en_o   (gate_en_o),
  .fault_evt_o (fault_evt_o),
  .oc_evt_o    (oc_evt_o),
  .ft_evt_o    (ft_evt_o)
);

// File: tb/fault_timer_ctrl_tb.sv
`timescale 1ns/1ps
module fault_timer_ctrl_tb;
  localparam int PRE = 10;
  localparam int CW  = 5;

  logic          clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b1;
  logic          en_i = 1'b0, oc_i = 1'b0, ft_i = 1'b0, retry_i = 1'b0;
  logic [CW-1:0] code_i = CW'(1);
  logic          gate, fevt, oevt, tevt;

  fault_timer_ctrl #(.PRESCALE(PRE), .CODE_W(CW), .COOL_SHIFT(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .en_i(en_i), .oc_i(oc_i),
    .fast_trip_i(ft_i), .ft_code_i(code_i), .retry_mode_i(retry_i),
    .gate_en_o(gate), .fault_evt_o(fevt), .oc_evt_o(oevt), .ft_evt_o(tevt)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         at;
    logic [3:0] val;
    logic [3:0] msk;
    string      req;
  } exp_t;
  exp_t sbq[$];

  int n_chk = 0, n_err = 0;
  bit half = 1'b0, done_f = 1'b0;

  // expected order of bits: {gate, fault, oc, fast}
  task automatic expect_all(int at, logic g, logic f, logic o, logic t, string req);
    sbq.push_back('{at, {g, f, o, t}, 4'hF, req});
  endtask

  task automatic expect_gate(int at, logic g, string req);
    sbq.push_back('{at, {g, 3'b000}, 4'b1000, req});
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  // tick source: every edge, or every other edge when half is set
  initial forever begin
    @(negedge clk);
    tick_i = half ? ~tick_i : 1'b1;
  end

  // monitor
  initial forever begin
    @(negedge clk);
    #1;
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].at == cyc) begin
        logic [3:0] act;
        act = {gate, fevt, oevt, tevt};
        n_chk++;
        if ((act & sbq[i].msk) !== (sbq[i].val & sbq[i].msk)) begin
          n_err++;
          $display("FAIL %s cycle %0d actual %b expected %b (mask %b)",
                   sbq[i].req, cyc, act, sbq[i].val, sbq[i].msk);
        end
        sbq.delete(i);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done_f) begin
      n_err++;
      $display("FAIL watchdog cycle %0d actual running expected finished", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int a, b, d, f, g, h;
    wait_cyc(3);
    rst_ni = 1'b1;
    expect_all(cyc, 0, 0, 0, 0, "R1");
    expect_all(cyc + 2, 0, 0, 0, 0, "R1");
    wait_cyc(3);

    // R2: enable
    code_i  = CW'(2);
    retry_i = 1'b0;
    en_i    = 1'b1;
    expect_all(cyc, 0, 0, 0, 0, "R2");
    expect_all(cyc + 1, 1, 0, 0, 0, "R2");
    wait_cyc(3);

    // R4/R9: short burst then full burst, budget 20 edges
    a = cyc;
    expect_all(a + 1, 1, 0, 1, 0, "R9");
    expect_all(a + 15, 1, 0, 0, 0, "R4");
    oc_i = 1'b1; wait_cyc(15); oc_i = 1'b0; wait_cyc(3);
    b = cyc;
    expect_all(b + 1, 1, 0, 1, 0, "R9");
    expect_all(b + 19, 1, 0, 0, 0, "R4");
    expect_all(b + 20, 0, 1, 0, 0, "R3");
    expect_all(b + 21, 0, 0, 0, 0, "R8");
    oc_i = 1'b1; wait_cyc(20); oc_i = 1'b0;

    // R5: latched until en toggles
    expect_all(cyc + 50, 0, 0, 0, 0, "R5");
    wait_cyc(50);
    en_i = 1'b0; wait_cyc(2); en_i = 1'b1;
    expect_all(cyc + 1, 1, 0, 0, 0, "R5");
    wait_cyc(3);

    // R3 code 0 as 1, R6 retry after 16x
    code_i  = '0;
    retry_i = 1'b1;
    d = cyc;
    expect_all(d + 9, 1, 0, 0, 0, "R3");
    expect_all(d + 10, 0, 1, 0, 0, "R3");
    expect_all(d + 169, 0, 0, 0, 0, "R6");
    expect_all(d + 170, 1, 0, 0, 0, "R6");
    oc_i = 1'b1; wait_cyc(10); oc_i = 1'b0; wait_cyc(165);

    // R7: fast trip with retry
    code_i = CW'(1);
    f = cyc;
    expect_all(f + 1, 0, 0, 0, 1, "R7");
    expect_all(f + 2, 0, 0, 0, 0, "R7");
    expect_all(f + 160, 0, 0, 0, 0, "R7");
    expect_all(f + 161, 1, 0, 0, 0, "R7");
    ft_i = 1'b1; wait_cyc(1); ft_i = 1'b0; wait_cyc(165);

    // R7: fast trip with latch-off
    retry_i = 1'b0;
    g = cyc;
    expect_all(g + 1, 0, 0, 0, 1, "R7");
    expect_all(g + 40, 0, 0, 0, 0, "R7");
    ft_i = 1'b1; wait_cyc(1); ft_i = 1'b0; wait_cyc(39);
    en_i = 1'b0; wait_cyc(2); en_i = 1'b1;
    expect_all(cyc + 1, 1, 0, 0, 0, "R2");
    wait_cyc(3);

    // R10: tick on every other edge doubles the time in clocks
    half = 1'b1;
    wait_cyc(4);
    a = cyc;
    expect_gate(a + 10, 1, "R10");
    expect_gate(a + 20, 0, "R10");
    oc_i = 1'b1; wait_cyc(20); oc_i = 1'b0;
    half = 1'b0;
    wait_cyc(3);

    // R2: disabled channel ignores over-current and fast trip
    en_i = 1'b0;
    expect_all(cyc + 1, 0, 0, 0, 0, "R2");
    wait_cyc(2);
    oc_i = 1'b1; ft_i = 1'b1;
    expect_all(cyc + 1, 0, 0, 0, 0, "R2");
    expect_all(cyc + 10, 0, 0, 0, 0, "R2");
    expect_all(cyc + 30, 0, 0, 0, 0, "R2");
    wait_cyc(30);
    oc_i = 1'b0; ft_i = 1'b0;
    wait_cyc(3);

    // R2: disable from the on state
    en_i = 1'b1;
    h = cyc;
    expect_all(h + 1, 1, 0, 0, 0, "R2");
    wait_cyc(1);
    en_i = 1'b0;
    expect_all(h + 2, 0, 0, 0, 0, "R2");
    wait_cyc(4);

    if (sbq.size() != 0) begin
      n_err += sbq.size();
      $display("FAIL pending %0d actual unchecked expected none", sbq.size());
    end
    done_f = 1'b1;
    summary();
    $finish;
  end
endmodule